// File: doc/BRIEF.md
# Bus Address Watchpoint

This block watches a stream of bus transactions and counts those that fall on a programmed address pattern. Each transaction carries an address, a read flag, a write flag and the index of the bus master that issued it. A transaction qualifies when three conditions hold together. Its master must be enabled in a per-master bitmask. Its direction must be enabled. Its address must meet the selected comparison: equal to one address, inside an inclusive window, or outside that window.

Software programs the watchpoint through a small register port with four word locations: control, status (read-only), lower bound and upper bound. Writing control arms a down-counter with an initial count. Every qualifying transaction lowers the count by one. A qualifying transaction that arrives while the count is already zero ends the search. The block then stays in a terminal state and raises a single-cycle pulse on either the exception output or the trap output, as the control word selects. It stays in the terminal state until control is written again. Combining several watchpoints and handling the pulse are left to the surrounding logic.

Top module: `addr_watchpoint`

## Requirements
- R1: After reset, reads of control, status, lower bound and upper bound all return zero, and both pulse outputs are low.
- R2: Writing control (reg_sel 0) loads the counter from control bits [31:16]. The state becomes searching (status bits [17:16] = 01) when the mode field, control bits [1:0], is nonzero, and disabled (00) when it is zero. Control reads back the written word.
- R3: Mode 01 qualifies a transaction only when its address equals the lower bound register (reg_sel 2).
- R4: Mode 10 qualifies addresses from the lower bound up to the upper bound (reg_sel 3), both bounds included, compared as unsigned. A window whose lower bound is above its upper bound qualifies nothing.
- R5: Mode 11 qualifies exactly the addresses that mode 10 rejects.
- R6: Control bits [7:2] enable masters 0 to 5, bit 2 standing for master 0. A transaction from a disabled master, or from an index of 6 or more, never qualifies.
- R7: Control bit 8 enables read transactions and bit 9 enables write transactions. A transaction qualifies when it has an enabled direction flag set.
- R8: While searching, each qualifying transaction with a nonzero count decrements the count. Status bits [15:0] show the count, and status is read at reg_sel 1.
- R9: A qualifying transaction while searching with a count of zero moves the state to expired (11) with the count held at 0. In the next cycle it raises one single-cycle pulse: exc_pulse for action 01 or trap_pulse for action 10, where the action is control bits [11:10]. Actions 00 and 11 produce no pulse.
- R10: In the expired state, further transactions change neither the status nor the outputs until control is written again.
- R11: In the disabled state, and whenever bus_valid is low, transactions change neither the count nor the state.
- R12: The lower and upper bound registers read back the values last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 lower bound, 3 upper bound |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| bus_valid | input | 1 | A transaction is present this cycle |
| bus_addr | input | ADDR_W | Transaction address |
| bus_rd | input | 1 | Transaction is a read |
| bus_wr | input | 1 | Transaction is a write |
| bus_master | input | MID_W | Index of the issuing master |
| exc_pulse | output | 1 | Single-cycle exception request on expiry |
| trap_pulse | output | 1 | Single-cycle trap request on expiry |

## Verification
The count and the state word can be read back after every transaction. A comparator, mask or direction fault therefore shows up at the status port one cycle later, as a count that is off by one. A fault in the expiry logic shows within one cycle of the terminal match: either a missing pulse, a pulse on the wrong output, a pulse longer than one cycle, or a state word other than 11. A terminal state that fails to hold shows on the very next qualifying transaction, as a changed status or a second pulse. Address sweeps across each bound, full sweeps of the master mask against every master index, and all combinations of direction enables and flags cover these paths.

// File: rtl/wp_pkg.sv
package wp_pkg;

   typedef enum logic [1:0] {
      MODE_OFF = 2'b00,
      MODE_EQ  = 2'b01,
      MODE_IN  = 2'b10,
      MODE_OUT = 2'b11
   } wp_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_HUNT = 2'b01,
      ST_DONE = 2'b11
   } wp_state_e;

   typedef enum logic [1:0] {
      ACT_NONE = 2'b00,
      ACT_EXC  = 2'b01,
      ACT_TRAP = 2'b10,
      ACT_RSVD = 2'b11
   } wp_act_e;

   localparam logic [1:0] SEL_CTRL = 2'd0;
   localparam logic [1:0] SEL_STAT = 2'd1;
   localparam logic [1:0] SEL_LO   = 2'd2;
   localparam logic [1:0] SEL_HI   = 2'd3;

   localparam int F_MODE  = 0;
   localparam int F_MASK  = 2;
   localparam int F_RDEN  = 8;
   localparam int F_WREN  = 9;
   localparam int F_ACT   = 10;
   localparam int F_COUNT = 16;

endpackage

// File: rtl/wp_regs.sv
module wp_regs
   import wp_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int N_MASTERS = 6,
   parameter int CNT_W     = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [1:0]           reg_sel,
   input  logic [31:0]          reg_wdata,
   input  logic [31:0]          status_word,
   output logic [31:0]          reg_rdata,
   output logic                 ctrl_load,
   output logic [1:0]           mode,
   output logic [N_MASTERS-1:0] mmask,
   output logic                 rd_en,
   output logic                 wr_en,
   output logic [1:0]           action,
   output logic [CNT_W-1:0]     init_cnt,
   output logic [ADDR_W-1:0]    lo_q,
   output logic [ADDR_W-1:0]    hi_q
);

   logic [31:0] ctrl_q;

   assign ctrl_load = reg_wr && (reg_sel == SEL_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
      end else if (reg_wr) begin
         case (reg_sel)
            SEL_CTRL: ctrl_q <= reg_wdata;
            SEL_LO:   lo_q   <= reg_wdata[ADDR_W-1:0];
            SEL_HI:   hi_q   <= reg_wdata[ADDR_W-1:0];
            default:  ;
         endcase
      end
   end

   assign mode     = ctrl_q[F_MODE +: 2];
   assign mmask    = ctrl_q[F_MASK +: N_MASTERS];
   assign rd_en    = ctrl_q[F_RDEN];
   assign wr_en    = ctrl_q[F_WREN];
   assign action   = ctrl_q[F_ACT +: 2];
   assign init_cnt = ctrl_q[F_COUNT +: CNT_W];

   always_comb begin
      case (reg_sel)
         SEL_CTRL: reg_rdata = ctrl_q;
         SEL_STAT: reg_rdata = status_word;
         SEL_LO:   reg_rdata = 32'(lo_q);
         default:  reg_rdata = 32'(hi_q);
      endcase
   end

endmodule

// File: rtl/wp_match.sv
module wp_match
   import wp_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int N_MASTERS = 6,
   parameter int MID_W     = 3
) (
   input  logic                 bus_valid,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_rd,
   input  logic                 bus_wr,
   input  logic [MID_W-1:0]     bus_master,
   input  logic [1:0]           mode,
   input  logic [N_MASTERS-1:0] mmask,
   input  logic                 rd_en,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    lo,
   input  logic [ADDR_W-1:0]    hi,
   output logic                 hit
);

   logic [N_MASTERS-1:0] owner_sel;
   logic                 owner_ok;
   logic                 dir_ok;
   logic                 eq_lo;
   logic                 above_lo;
   logic                 below_hi;
   logic                 in_win;
   logic                 addr_ok;

   for (genvar i = 0; i < N_MASTERS; i++) begin : g_owner
      assign owner_sel[i] = mmask[i] && (bus_master == MID_W'(i));
   end

   assign owner_ok = |owner_sel;
   assign dir_ok   = (bus_rd && rd_en) || (bus_wr && wr_en);

   assign eq_lo    = (bus_addr == lo);
   assign above_lo = (bus_addr >= lo);
   assign below_hi = (bus_addr <= hi);
   assign in_win   = above_lo && below_hi;

   always_comb begin
      case (mode)
         MODE_EQ:  addr_ok = eq_lo;
         MODE_IN:  addr_ok = in_win;
         MODE_OUT: addr_ok = !in_win;
         default:  addr_ok = 1'b0;
      endcase
   end

   assign hit = bus_valid && owner_ok && dir_ok && addr_ok;

endmodule

// File: rtl/wp_count.sv
module wp_count
   import wp_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             arm,
   input  logic [1:0]       action,
   input  logic             hit,
   output wp_state_e        state,
   output logic [CNT_W-1:0] cnt,
   output logic             exc_pulse,
   output logic             trap_pulse
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         exc_pulse  <= 1'b0;
         trap_pulse <= 1'b0;
      end else begin
         exc_pulse  <= 1'b0;
         trap_pulse <= 1'b0;
         if (load) begin
            cnt   <= load_val;
            state <= arm ? ST_HUNT : ST_IDLE;
         end else if (state == ST_HUNT && hit) begin
            if (cnt == '0) begin
               state      <= ST_DONE;
               exc_pulse  <= (action == ACT_EXC);
               trap_pulse <= (action == ACT_TRAP);
            end else begin
               cnt <= cnt - CNT_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/addr_watchpoint.sv
module addr_watchpoint
   import wp_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int N_MASTERS = 6,
   parameter int MID_W     = 3,
   parameter int CNT_W     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              bus_valid,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [MID_W-1:0]  bus_master,
   output logic              exc_pulse,
   output logic              trap_pulse
);

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
      $error("addr_watchpoint: ADDR_W must lie in 1..32");
   end
   if (N_MASTERS < 1 || N_MASTERS > 6) begin : g_bad_masters
      $error("addr_watchpoint: N_MASTERS must lie in 1..6");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt_w
      $error("addr_watchpoint: CNT_W must lie in 1..16");
   end
   if ((1 << MID_W) < N_MASTERS) begin : g_bad_mid_w
      $error("addr_watchpoint: MID_W too narrow for N_MASTERS");
   end

   logic                 ctrl_load;
   logic [1:0]           mode;
   logic [N_MASTERS-1:0] mmask;
   logic                 rd_en;
   logic                 wr_en;
   logic [1:0]           action;
   logic [CNT_W-1:0]     load_val;
   logic [ADDR_W-1:0]    lo_q;
   logic [ADDR_W-1:0]    hi_q;
   logic                 hit;
   wp_state_e            cur_state;
   logic [1:0]           wp_state;
   logic [CNT_W-1:0]     wp_cnt;
   logic [31:0]          status_word;

   assign wp_state    = cur_state;
   assign status_word = {14'd0, wp_state, 16'(wp_cnt)};

   wp_regs #(
      .ADDR_W    (ADDR_W),
      .N_MASTERS (N_MASTERS),
      .CNT_W     (CNT_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr      (reg_wr),
      .reg_sel     (reg_sel),
      .reg_wdata   (reg_wdata),
      .status_word (status_word),
      .reg_rdata   (reg_rdata),
      .ctrl_load   (ctrl_load),
      .mode        (mode),
      .mmask       (mmask),
      .rd_en       (rd_en),
      .wr_en       (wr_en),
      .action      (action),
      .init_cnt    (load_val),
      .lo_q        (lo_q),
      .hi_q        (hi_q)
   );

   wp_match #(
      .ADDR_W    (ADDR_W),
      .N_MASTERS (N_MASTERS),
      .MID_W     (MID_W)
   ) u_match (
      .bus_valid  (bus_valid),
      .bus_addr   (bus_addr),
      .bus_rd     (bus_rd),
      .bus_wr     (bus_wr),
      .bus_master (bus_master),
      .mode       (mode),
      .mmask      (mmask),
      .rd_en      (rd_en),
      .wr_en      (wr_en),
      .lo         (lo_q),
      .hi         (hi_q),
      .hit        (hit)
   );

   wp_count #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (ctrl_load),
      .load_val   (reg_wdata[F_COUNT +: CNT_W]),
      .arm        (reg_wdata[F_MODE +: 2] != MODE_OFF),
      .action     (action),
      .hit        (hit),
      .state      (cur_state),
      .cnt        (wp_cnt),
      .exc_pulse  (exc_pulse),
      .trap_pulse (trap_pulse)
   );

endmodule

// File: rtl/wp_checker.sv
module wp_checker
   import wp_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctrl_load,
   input logic [CNT_W-1:0] load_val,
   input logic             hit,
   input logic [1:0]       state,
   input logic [CNT_W-1:0] cnt,
   input logic             exc,
   input logic             trap
);

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_load |=> (cnt == $past(load_val) && state != ST_DONE));

   p_decrement_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HUNT && hit && !ctrl_load && cnt != '0)
      |=> (state == ST_HUNT && cnt == CNT_W'($past(cnt) - 1'b1)));

   p_no_hit_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HUNT && !hit && !ctrl_load) |=> (state == ST_HUNT && $stable(cnt)));

   p_pulse_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(exc && trap));

   p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (exc || trap) |=> !(exc || trap));

   p_pulse_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (exc || trap) |-> (state == ST_DONE && cnt == '0));

   p_done_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DONE && !ctrl_load) |=> (state == ST_DONE && $stable(cnt)));

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !ctrl_load) |=> (state == ST_IDLE && $stable(cnt) && !exc && !trap));

endmodule

bind addr_watchpoint wp_checker #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctrl_load (ctrl_load),
   .load_val  (reg_wdata[16 +: CNT_W]),
   .hit       (hit),
   .state     (wp_state),
   .cnt       (wp_cnt),
   .exc       (exc_pulse),
   .trap      (trap_pulse)
);

// File: tb/addr_watchpoint_tb.sv
`timescale 1ns/1ps
module addr_watchpoint_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        bus_valid = 1'b0;
   logic [31:0] bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_master = '0;
   logic        exc_pulse;
   logic        trap_pulse;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   addr_watchpoint u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_sel    (reg_sel),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .bus_valid  (bus_valid),
      .bus_addr   (bus_addr),
      .bus_rd     (bus_rd),
      .bus_wr     (bus_wr),
      .bus_master (bus_master),
      .exc_pulse  (exc_pulse),
      .trap_pulse (trap_pulse)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] sel, input logic [31:0] data);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] sel, output logic [31:0] data);
      reg_sel = sel;
      #1;
      data = reg_rdata;
   endtask

   task automatic xact(input logic [31:0] a, input logic r, input logic w,
                       input logic [2:0] m, input logic v);
      @(negedge clk);
      bus_valid = v; bus_addr = a; bus_rd = r; bus_wr = w; bus_master = m;
      @(negedge clk);
      bus_valid = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
   endtask

   function automatic logic [31:0] ctrl_word(input int count, input int act, input bit wen,
                                             input bit ren, input int mask, input int mode);
      return {16'(count), 4'd0, 2'(act), wen, ren, 6'(mask), 2'(mode)};
   endfunction

   function automatic bit addr_hit(input int mode, input logic [31:0] a,
                                   input logic [31:0] lo, input logic [31:0] hi);
      bit inside_w;
      inside_w = (a >= lo) && (a <= hi);
      case (mode)
         1: return a == lo;
         2: return inside_w;
         3: return !inside_w;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [31:0] stat(input logic [1:0] st, input int count);
      return {14'd0, st, 16'(count)};
   endfunction

   task automatic sweep_addr(input int mode, input logic [31:0] lo, input logic [31:0] hi,
                             input logic [31:0] first, input int n, input string req);
      logic [31:0] rd;
      int exp_cnt;
      wr_reg(2'd2, lo);
      wr_reg(2'd3, hi);
      wr_reg(2'd0, ctrl_word(1000, 0, 0, 1, 6'h3F, mode));
      exp_cnt = 1000;
      for (int k = 0; k < n; k++) begin
         logic [31:0] a;
         a = first + 32'(k);
         xact(a, 1'b1, 1'b0, 3'd0, 1'b1);
         if (addr_hit(mode, a, lo, hi)) exp_cnt--;
         rd_reg(2'd1, rd);
         check(req, rd, stat(2'b01, exp_cnt));
      end
   endtask

   initial begin
      logic [31:0] rd;
      int exp_cnt;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_reg(2'd0, rd); check("R1 ctrl", rd, 32'd0);
      rd_reg(2'd1, rd); check("R1 status", rd, 32'd0);
      rd_reg(2'd2, rd); check("R1 lo", rd, 32'd0);
      rd_reg(2'd3, rd); check("R1 hi", rd, 32'd0);
      check("R1 pulses", {30'd0, exc_pulse, trap_pulse}, 32'd0);

      // R12 bound readback
      wr_reg(2'd2, 32'hA5A5_0001);
      wr_reg(2'd3, 32'h5A5A_FFFE);
      rd_reg(2'd2, rd); check("R12 lo", rd, 32'hA5A5_0001);
      rd_reg(2'd3, rd); check("R12 hi", rd, 32'h5A5A_FFFE);

      // R3 R4 R5 address sweeps across both bounds
      sweep_addr(1, 32'h100, 32'h108, 32'hFC, 17, "R3 single");
      sweep_addr(2, 32'h100, 32'h108, 32'hFC, 17, "R4 window");
      sweep_addr(3, 32'h100, 32'h108, 32'hFC, 17, "R5 outside");
      sweep_addr(2, 32'h8000_0000, 32'hFFFF_FFFF, 32'h7FFF_FFFE, 4, "R4 unsigned");
      sweep_addr(2, 32'hFFFF_FFFD, 32'hFFFF_FFFF, 32'hFFFF_FFFC, 4, "R4 top");
      sweep_addr(2, 32'h200, 32'h100, 32'hFF, 4, "R4 inverted");
      sweep_addr(3, 32'h200, 32'h100, 32'hFF, 4, "R5 inverted");

      // R6 every master mask against every master index
      wr_reg(2'd2, 32'h40);
      for (int mask = 0; mask < 64; mask++) begin
         wr_reg(2'd0, ctrl_word(100, 0, 0, 1, mask, 1));
         exp_cnt = 100;
         for (int m = 0; m < 8; m++) begin
            xact(32'h40, 1'b1, 1'b0, 3'(m), 1'b1);
            if (m < 6 && mask[m]) exp_cnt--;
         end
         rd_reg(2'd1, rd);
         check("R6 master mask", rd, stat(2'b01, exp_cnt));
      end

      // R7 direction enables against direction flags
      for (int en = 0; en < 4; en++) begin
         for (int t = 0; t < 4; t++) begin
            bit hit_exp;
            wr_reg(2'd0, ctrl_word(50, 0, en[1], en[0], 6'h3F, 1));
            xact(32'h40, t[0], t[1], 3'd2, 1'b1);
            hit_exp = (t[0] && en[0]) || (t[1] && en[1]);
            rd_reg(2'd1, rd);
            check("R7 direction", rd, stat(2'b01, hit_exp ? 49 : 50));
         end
      end

      // R8 R9 R10 countdown, expiry and action select
      for (int act = 0; act < 4; act++) begin
         for (int n = 0; n <= 2; n += 2) begin
            wr_reg(2'd0, ctrl_word(n, act, 1, 1, 6'h3F, 1));
            rd_reg(2'd1, rd);
            check("R2 load", rd, stat(2'b01, n));
            for (int k = n - 1; k >= 0; k--) begin
               xact(32'h40, 1'b0, 1'b1, 3'd5, 1'b1);
               rd_reg(2'd1, rd);
               check("R8 decrement", rd, stat(2'b01, k));
               check("R8 no pulse", {30'd0, exc_pulse, trap_pulse}, 32'd0);
            end
            xact(32'h40, 1'b1, 1'b0, 3'd3, 1'b1);
            check("R9 pulses", {30'd0, exc_pulse, trap_pulse},
                  {30'd0, 1'(act == 1), 1'(act == 2)});
            rd_reg(2'd1, rd);
            check("R9 expired", rd, stat(2'b11, 0));
            @(negedge clk);
            check("R9 pulse width", {30'd0, exc_pulse, trap_pulse}, 32'd0);
            for (int k = 0; k < 2; k++) begin
               xact(32'h40, 1'b1, 1'b0, 3'd0, 1'b1);
               check("R10 no repeat pulse", {30'd0, exc_pulse, trap_pulse}, 32'd0);
               rd_reg(2'd1, rd);
               check("R10 hold", rd, stat(2'b11, 0));
            end
         end
      end
      wr_reg(2'd0, ctrl_word(5, 1, 0, 1, 6'h3F, 1));
      rd_reg(2'd1, rd);
      check("R10 rewrite rearms", rd, stat(2'b01, 5));

      // R2 R11 disabled mode
      wr_reg(2'd0, ctrl_word(7, 1, 1, 1, 6'h3F, 0));
      rd_reg(2'd0, rd);
      check("R2 ctrl readback", rd, ctrl_word(7, 1, 1, 1, 6'h3F, 0));
      rd_reg(2'd1, rd);
      check("R2 disabled", rd, stat(2'b00, 7));
      for (int k = 0; k < 3; k++) xact(32'h40, 1'b1, 1'b1, 3'd0, 1'b1);
      rd_reg(2'd1, rd);
      check("R11 disabled ignores", rd, stat(2'b00, 7));

      // R11 bus_valid low
      wr_reg(2'd0, ctrl_word(0, 2, 1, 1, 6'h3F, 1));
      xact(32'h40, 1'b1, 1'b1, 3'd0, 1'b0);
      check("R11 invalid no pulse", {30'd0, exc_pulse, trap_pulse}, 32'd0);
      rd_reg(2'd1, rd);
      check("R11 invalid ignored", rd, stat(2'b01, 0));
      xact(32'h40, 1'b1, 1'b1, 3'd0, 1'b1);
      check("R9 trap", {30'd0, exc_pulse, trap_pulse}, 32'd1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule